// File: doc/BRIEF.md
# Gated Pulse Accumulator

This block is an 8-bit counting peripheral driven by a single external input pin. Software reaches it through a small register bus holding a control register, a count register and a flag register. In event mode the count goes up by one on each chosen transition of the pin. In gated mode the pin acts as a gate. While the gate is open, the count goes up once per period of a free-running internal time base. The same measurement is possible with either pin polarity.

A single polarity bit has a different meaning in each mode. In event mode it picks which transition is counted. In gated mode it picks the pin level that holds the count still. Two sticky flags are kept: one for the count wrapping past its top value, and one for the active transition of the pin. Both flags are driven onto output ports and can be read over the bus. Reset clears the control and flag state but leaves the count register untouched. A previously stored count therefore survives a reset.

Top module: `pacc_top`

## Requirements
- R1: After reset the control register (address 0) reads 0x00, the flag register (address 2) reads 0x00, and both flag outputs are low.
- R2: Reset does not alter the count register (address 1). A value written before reset reads back unchanged after it.
- R3: Control bit 6 is enable, bit 5 is mode (0 event, 1 gated) and bit 4 is polarity. Bits 2:0 are plain storage that reads back as written. Bits 7 and 3 always read 0, and writes to them are ignored.
- R4: While enable is 0 the count never changes except by a bus write, and the edge flag is not set, whatever the pin does.
- R5: Event mode with polarity 0 adds one to the count for each falling transition of the pin.
- R6: Event mode with polarity 1 adds one to the count for each rising transition of the pin.
- R7: Gated mode adds one to the count once every 64 clock cycles while the gate is open. A free-running divider sets this rate, so an open window of N cycles adds N/64 rounded down or up. Polarity 0 holds the count while the pin is low, and polarity 1 holds it while the pin is high.
- R8: A count step from 0xFF to 0x00 sets the sticky overflow flag, which is bit 0 of address 2 and drives the ovf_flag port.
- R9: The edge flag is sticky. It is bit 1 of address 2 and drives the edge_flag port. It is set by a counted transition in event mode, or by the pin entering its holding level in gated mode.
- R10: Writing address 2 clears each flag whose bit is written as 1. A flag whose bit is written as 0 is unchanged.
- R11: A bus write to the count in the same cycle as an increment loads the written value. That cycle does not set the overflow flag.
- R12: Read data is registered. It shows the addressed register one cycle after the address is presented, and address 3 reads 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Register address |
| bus_we | input | 1 | Write strobe for the addressed register |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| pa_pin | input | 1 | Asynchronous external count or gate input |
| ovf_flag | output | 1 | Sticky count-wrap flag |
| edge_flag | output | 1 | Sticky active-transition flag |

## Verification
The hardest case to reach is a count write that lands in the same cycle as a gated increment. The divider phase cannot be seen at the ports, so the bench cannot aim a single write at a tick. Instead, it opens the gate and writes 0xFF to the count on every cycle for longer than several divider periods. This forces some write to coincide with a tick. If an increment ever won, the count would wrap and the overflow flag would rise. The burst ends with a small value so that a tick landing just after it cannot wrap the count.

// File: rtl/pacc_pkg.sv
package pacc_pkg;
  localparam int BUS_W  = 8;
  localparam int ADDR_W = 2;

  localparam logic [ADDR_W-1:0] A_CTRL  = 2'd0;
  localparam logic [ADDR_W-1:0] A_COUNT = 2'd1;
  localparam logic [ADDR_W-1:0] A_FLAGS = 2'd2;

  localparam int B_EN   = 6;
  localparam int B_MODE = 5;
  localparam int B_POL  = 4;

  localparam int F_OVF  = 0;
  localparam int F_EDGE = 1;

  typedef struct packed {
    logic       en;
    logic       gated;
    logic       pol;
    logic [2:0] spare;
  } ctrl_t;
endpackage

// File: rtl/pacc_insync.sv
module pacc_insync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic level_o,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= din;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= {chain_q[STAGES-2:0], din};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= chain_q[STAGES-1];
  end

  assign level_o = chain_q[STAGES-1];
  assign rise_o  = chain_q[STAGES-1] & ~prev_q;
  assign fall_o  = ~chain_q[STAGES-1] & prev_q;

  // R5
  fall_follows_high_chk: assert property (@(posedge clk) disable iff (rst)
    fall_o |-> $past(level_o));
endmodule

// File: rtl/pacc_prescaler.sv
module pacc_prescaler #(
  parameter int DIV = 64
) (
  input  logic clk,
  input  logic rst,
  output logic tick_o
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] div_q;

  always_ff @(posedge clk) begin
    if (rst)               div_q <= '0;
    else if (div_q == LAST) div_q <= '0;
    else                   div_q <= div_q + 1'b1;
  end

  assign tick_o = (div_q == LAST);

  // R7
  tick_spacing_chk: assert property (@(posedge clk) disable iff (rst)
    tick_o |=> !tick_o);
endmodule

// File: rtl/pacc_counter.sv
module pacc_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_i,
  input  logic [CNT_W-1:0] wdata_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);
  localparam logic [CNT_W-1:0] TOP = '1;

  logic [CNT_W-1:0] cnt_q;

  // Count holds its value through reset by design.
  always_ff @(posedge clk) begin
    if (wr_i)       cnt_q <= wdata_i;
    else if (inc_i) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o  = cnt_q;
  assign wrap_o = inc_i & ~wr_i & (cnt_q == TOP);

  // R11
  write_priority_chk: assert property (@(posedge clk) disable iff (rst)
    wr_i |=> (cnt_q == $past(wdata_i)));
endmodule

// File: rtl/pacc_regs.sv
module pacc_regs
  import pacc_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [BUS_W-1:0]  wdata_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              ovf_set_i,
  input  logic              edge_set_i,
  output ctrl_t             ctrl_o,
  output logic              cnt_we_o,
  output logic              ovf_o,
  output logic              edge_o,
  output logic [BUS_W-1:0]  rdata_o
);
  ctrl_t            ctrl_q;
  logic             ovf_q, edge_q;
  logic             flag_wr;
  logic [BUS_W-1:0] rd_next;

  assign flag_wr  = we_i && (addr_i == A_FLAGS);
  assign cnt_we_o = we_i && (addr_i == A_COUNT);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
    end else if (we_i && addr_i == A_CTRL) begin
      ctrl_q.en    <= wdata_i[B_EN];
      ctrl_q.gated <= wdata_i[B_MODE];
      ctrl_q.pol   <= wdata_i[B_POL];
      ctrl_q.spare <= wdata_i[2:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ovf_q  <= 1'b0;
      edge_q <= 1'b0;
    end else begin
      ovf_q  <= (ovf_q  & ~(flag_wr & wdata_i[F_OVF]))  | ovf_set_i;
      edge_q <= (edge_q & ~(flag_wr & wdata_i[F_EDGE])) | edge_set_i;
    end
  end

  always_comb begin
    rd_next = '0;
    case (addr_i)
      A_CTRL: begin
        rd_next[B_EN]   = ctrl_q.en;
        rd_next[B_MODE] = ctrl_q.gated;
        rd_next[B_POL]  = ctrl_q.pol;
        rd_next[2:0]    = ctrl_q.spare;
      end
      A_COUNT: rd_next[CNT_W-1:0] = cnt_i;
      A_FLAGS: begin
        rd_next[F_OVF]  = ovf_q;
        rd_next[F_EDGE] = edge_q;
      end
      default: rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_o <= '0;
    else     rdata_o <= rd_next;
  end

  assign ctrl_o = ctrl_q;
  assign ovf_o  = ovf_q;
  assign edge_o = edge_q;

  // R3
  ctrl_hole_chk: assert property (@(posedge clk) disable iff (rst)
    (addr_i == A_CTRL) |=> (rdata_o[7] == 1'b0 && rdata_o[3] == 1'b0));
  // R10
  ovf_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (flag_wr && wdata_i[F_OVF] && !ovf_set_i) |=> !ovf_o);
  // R12
  empty_addr_chk: assert property (@(posedge clk) disable iff (rst)
    (addr_i == 2'd3) |=> (rdata_o == '0));
endmodule

// File: rtl/pacc_top.sv
module pacc_top
  import pacc_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2,
  parameter int PRESCALE    = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  input  logic              pa_pin,
  output logic              ovf_flag,
  output logic              edge_flag
);
  ctrl_t            ctrl;
  logic             pin_lvl, pin_rise, pin_fall;
  logic             tick;
  logic             cnt_we, inc, wrap, active_edge, gate_open, edge_set;
  logic [CNT_W-1:0] cnt;

  pacc_insync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst(rst), .din(pa_pin),
    .level_o(pin_lvl), .rise_o(pin_rise), .fall_o(pin_fall)
  );

  pacc_prescaler #(.DIV(PRESCALE)) presc_i (
    .clk(clk), .rst(rst), .tick_o(tick)
  );

  // Polarity picks the counted edge in event mode; in gated mode the same
  // edge is the pin entering its holding level, i.e. the gate closing.
  assign active_edge = ctrl.pol ? pin_rise : pin_fall;
  assign gate_open   = pin_lvl ^ ctrl.pol;

  assign inc = ctrl.en & (ctrl.gated ? (gate_open & tick) : active_edge);
  assign edge_set = ctrl.en & active_edge;

  pacc_counter #(.CNT_W(CNT_W)) cnt_i (
    .clk(clk), .rst(rst), .wr_i(cnt_we), .wdata_i(bus_wdata[CNT_W-1:0]),
    .inc_i(inc), .cnt_o(cnt), .wrap_o(wrap)
  );

  pacc_regs #(.CNT_W(CNT_W)) regs_i (
    .clk(clk), .rst(rst), .addr_i(bus_addr), .we_i(bus_we),
    .wdata_i(bus_wdata), .cnt_i(cnt), .ovf_set_i(wrap), .edge_set_i(edge_set),
    .ctrl_o(ctrl), .cnt_we_o(cnt_we), .ovf_o(ovf_flag), .edge_o(edge_flag),
    .rdata_o(bus_rdata)
  );

  // R4
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!ctrl.en && !cnt_we) |=> $stable(cnt));
  // R8
  ovf_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ovf_flag) |-> ($past(cnt) == '1 && cnt == '0));
  // R9
  edge_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(edge_flag) |-> $past(ctrl.en));
endmodule

// File: tb/pacc_top_tb_top.sv
module pacc_top_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] bus_addr = '0;
  logic       bus_we = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       pa_pin = 1'b0;
  logic       ovf_flag, edge_flag;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  pacc_top dut_i (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pa_pin(pa_pin),
    .ovf_flag(ovf_flag), .edge_flag(edge_flag)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic chk_rng(input string req, input int act, input int lo, input int hi);
    checks++;
    if (act < lo || act > hi) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d..%0d", req, act, lo, hi);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b0;
    @(negedge clk);
    v = bus_rdata;
  endtask

  task automatic pin_to(input logic v);
    @(negedge clk);
    pa_pin = v;
    cyc(4);
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      pin_to(~pa_pin);
      pin_to(~pa_pin);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    cyc(3);
    rst = 1'b0;
    cyc(1);
  endtask

  task automatic t_reset_state();
    logic [7:0] v;
    rd(2'd0, v); chk("R1 ctrl after reset", v, 8'h00);
    rd(2'd2, v); chk("R1 flags after reset", v, 8'h00);
    chk("R1 ovf_flag", ovf_flag, 0);
    chk("R1 edge_flag", edge_flag, 0);
  endtask

  task automatic t_ctrl_bits();
    logic [7:0] v;
    wr(2'd0, 8'h8F); rd(2'd0, v); chk("R3 holes ignored, spare kept", v, 8'h07);
    wr(2'd0, 8'hFF); rd(2'd0, v); chk("R3 all writable bits", v, 8'h77);
    wr(2'd0, 8'h00); rd(2'd0, v); chk("R3 cleared", v, 8'h00);
  endtask

  task automatic t_addr3();
    logic [7:0] v;
    rd(2'd3, v); chk("R12 address 3 reads zero", v, 8'h00);
  endtask

  task automatic t_disabled();
    logic [7:0] v;
    wr(2'd0, 8'h10); wr(2'd2, 8'h03); wr(2'd1, 8'h33);
    pulses(5);
    rd(2'd1, v); chk("R4 count unchanged when disabled", v, 8'h33);
    chk("R4 edge flag stays low", edge_flag, 0);
    wr(2'd0, 8'h30);
    pin_to(1'b1); cyc(300); pin_to(1'b0);
    rd(2'd1, v); chk("R4 gated disabled unchanged", v, 8'h33);
  endtask

  task automatic t_event_fall();
    logic [7:0] v;
    pin_to(1'b0);
    wr(2'd0, 8'h40); wr(2'd1, 8'h00); wr(2'd2, 8'h03);
    pin_to(1'b1);
    rd(2'd1, v); chk("R5 rising not counted", v, 8'h00);
    chk("R9 no edge flag on rise with pol 0", edge_flag, 0);
    pin_to(1'b0);
    rd(2'd1, v); chk("R5 one falling edge", v, 8'h01);
    chk("R9 edge flag on falling", edge_flag, 1);
    pulses(3);
    rd(2'd1, v); chk("R5 four falling edges", v, 8'h04);
  endtask

  task automatic t_event_rise();
    logic [7:0] v;
    pin_to(1'b0);
    wr(2'd0, 8'h50); wr(2'd1, 8'h10); wr(2'd2, 8'h03);
    pulses(3);
    rd(2'd1, v); chk("R6 three rising edges", v, 8'h13);
    chk("R9 edge flag on rising with pol 1", edge_flag, 1);
  endtask

  task automatic t_gated(input logic pol);
    logic [7:0] v;
    int base;
    logic open_lvl;
    open_lvl = ~pol;
    wr(2'd0, 8'h00);
    pin_to(pol);
    wr(2'd0, pol ? 8'h70 : 8'h60); wr(2'd1, 8'h00); wr(2'd2, 8'h03);
    cyc(300);
    rd(2'd1, v); chk(pol ? "R7 pol1 high holds count" : "R7 pol0 low holds count", v, 0);
    chk("R9 no edge flag while closed", edge_flag, 0);
    @(negedge clk); pa_pin = open_lvl;
    cyc(640);
    @(negedge clk); pa_pin = pol;
    cyc(4);
    rd(2'd1, v);
    chk_rng(pol ? "R7 pol1 640-cycle window" : "R7 pol0 640-cycle window", v, 10, 11);
    chk("R9 edge flag on gate close", edge_flag, 1);
    base = v;
    cyc(200);
    rd(2'd1, v); chk("R7 frozen after gate close", v, base);
  endtask

  task automatic t_overflow();
    logic [7:0] v;
    wr(2'd0, 8'h00); pin_to(1'b0);
    wr(2'd0, 8'h50); wr(2'd1, 8'hFE); wr(2'd2, 8'h03);
    pulses(1);
    rd(2'd1, v); chk("R8 at 0xFF", v, 8'hFF);
    chk("R8 no overflow yet", ovf_flag, 0);
    pulses(1);
    rd(2'd1, v); chk("R8 wrapped to 0", v, 8'h00);
    chk("R8 ovf_flag set", ovf_flag, 1);
    rd(2'd2, v); chk("R8 flag register bit 0", v & 8'h01, 8'h01);
  endtask

  task automatic t_clear();
    logic [7:0] v;
    wr(2'd0, 8'h00);
    wr(2'd2, 8'h00); rd(2'd2, v); chk("R10 zero write keeps both", v, 8'h03);
    wr(2'd2, 8'h02); rd(2'd2, v); chk("R10 clear edge only", v, 8'h01);
    wr(2'd2, 8'h01); rd(2'd2, v); chk("R10 clear overflow", v, 8'h00);
    chk("R10 ovf_flag low", ovf_flag, 0);
  endtask

  task automatic t_write_wins();
    logic [7:0] v;
    wr(2'd0, 8'h00); wr(2'd1, 8'h00); wr(2'd2, 8'h03);
    pin_to(1'b1);
    wr(2'd0, 8'h60);
    @(negedge clk);
    bus_addr = 2'd1; bus_we = 1'b1; bus_wdata = 8'hFF;
    cyc(200);
    bus_wdata = 8'h10;
    @(negedge clk);
    bus_we = 1'b0;
    wr(2'd0, 8'h00);
    chk("R11 no overflow from colliding writes", ovf_flag, 0);
    rd(2'd1, v); chk_rng("R11 count after last write", v, 8'h10, 8'h11);
    pin_to(1'b0);
  endtask

  task automatic t_keep_on_reset();
    logic [7:0] v;
    wr(2'd0, 8'h00); wr(2'd1, 8'h5A);
    do_reset();
    rd(2'd1, v); chk("R2 count survives reset", v, 8'h5A);
    rd(2'd0, v); chk("R1 ctrl cleared by later reset", v, 8'h00);
  endtask

  initial begin
    cyc(3);
    rst = 1'b0;
    cyc(1);
    t_reset_state();
    t_ctrl_bits();
    t_addr3();
    t_disabled();
    t_event_fall();
    t_event_rise();
    t_gated(1'b0);
    t_gated(1'b1);
    t_overflow();
    t_clear();
    t_write_wins();
    t_keep_on_reset();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule